// File: doc/BRIEF.md
# Packed Lane Logic Permute Unit

This block is a single-stage datapath for a short-vector execution pipe. Each operand is 128 bits wide and is viewed as four 32-bit lanes. Lane 0 occupies bits 31:0 and lane 3 occupies bits 127:96. A 4-bit operation code selects one of the following:

- a full-width bitwise logic function;
- an immediate-steered lane shuffle;
- a lane interleave of the low or high halves;
- a half-register move between the two operands.

The result is captured one clock after an input strobe. It is then held until the next strobe.

A two-state sequencer drives the output strobe:

- `ST_IDLE` means no fresh result is presented.
- `ST_EMIT` means the result register was loaded on the previous edge.

There are two transitions:

- "accept": any state goes to `ST_EMIT` when the input strobe is high.
- "drain": any state goes to `ST_IDLE` when the input strobe is low.

Back-to-back strobes keep the sequencer in `ST_EMIT`. An unassigned operation code copies the first operand to the result and raises an illegal-operation flag. That flag is registered together with the result.

Top module: `lane_permute_unit`

## Requirements
- R1: While reset is asserted, and on the first sampling after it, `out_valid`, `result` and `illegal` are all zero.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R3: When `in_valid` is low, `result` and `illegal` keep their previous values.
- R4: Code 0 gives `a & b`, code 2 gives `a | b` and code 3 gives `a ^ b`, across all 128 bits.
- R5: Code 1 gives `~a & b`: the complement applies to the first operand.
- R6: Code 4 is a shuffle that reads `imm` as four 2-bit fields. `imm[1:0]` is the index for result lane 0 and `imm[7:6]` is the index for result lane 3. Lanes 0 and 1 come from operand a, and lanes 2 and 3 come from operand b.
- R7: Code 5 (interleave low) gives lanes 0 to 3 = a0, b0, a1, b1.
- R8: Code 6 (interleave high) gives lanes 0 to 3 = a2, b2, a3, b3.
- R9: Code 7 (high half to low) gives lanes 0 to 3 = b2, b3, a2, a3.
- R10: Code 8 (low half to high) gives lanes 0 to 3 = a0, a1, b0, b1.
- R11: Codes 9 to 15 load `result` with operand a unchanged and set `illegal`. Codes 0 to 8 clear `illegal`.
- R12: `imm` has no effect on the result of any code other than 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code |
| imm | input | 8 | Shuffle lane-index fields |
| opa | input | 128 | First operand (lanes a0..a3) |
| opb | input | 128 | Second operand (lanes b0..b3) |
| out_valid | output | 1 | Result loaded on the previous edge |
| result | output | 128 | Registered result |
| illegal | output | 1 | Registered unassigned-code flag |

## Verification
Two functions can fall in the same cycle: emitting one result and accepting the next strobe. This includes the case where the strobes alternate between an unassigned code and an assigned one. The bench provokes it with runs of back-to-back strobes that mix codes 9 to 15 with shuffles and interleaves. On every clock it checks three things against its own lane-level model: `out_valid` stays high, `result` changes to the new operation's value, and `illegal` follows the code of the latest strobe rather than a stale one. Idle gaps between the runs confirm that the held values are unchanged.

// File: rtl/plu_pkg.sv
package plu_pkg;

    typedef enum logic [3:0] {
        OPC_AND   = 4'd0,
        OPC_ANDN  = 4'd1,
        OPC_OR    = 4'd2,
        OPC_XOR   = 4'd3,
        OPC_SHUF  = 4'd4,
        OPC_ILVLO = 4'd5,
        OPC_ILVHI = 4'd6,
        OPC_HI2LO = 4'd7,
        OPC_LO2HI = 4'd8
    } opcode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

endpackage

// File: rtl/plu_bitwise.sv
module plu_bitwise #(
    parameter int VEC_W = 128
) (
    input  logic [3:0]       op_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] res_o,
    output logic             hit_o
);
    import plu_pkg::*;

    always_comb begin
        res_o = '0;
        hit_o = 1'b1;
        unique case (op_i)
            OPC_AND:  res_o = a_i & b_i;
            OPC_ANDN: res_o = ~a_i & b_i;
            OPC_OR:   res_o = a_i | b_i;
            OPC_XOR:  res_o = a_i ^ b_i;
            default:  hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/plu_lane_route.sv
module plu_lane_route #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int SEL_W = $clog2(LANES),
    localparam int IMM_W = LANES * SEL_W,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic [3:0]       op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] res_o,
    output logic             hit_o
);
    import plu_pkg::*;

    localparam int HALF = LANES / 2;

    logic [LANE_W-1:0] a_l   [LANES];
    logic [LANE_W-1:0] b_l   [LANES];
    logic [LANE_W-1:0] shf_l [LANES];
    logic [LANE_W-1:0] ilo_l [LANES];
    logic [LANE_W-1:0] ihi_l [LANES];
    logic [LANE_W-1:0] h2l_l [LANES];
    logic [LANE_W-1:0] l2h_l [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign a_l[g] = a_i[g*LANE_W +: LANE_W];
        assign b_l[g] = b_i[g*LANE_W +: LANE_W];
    end

    // Shuffle: the low half indexes operand a, the high half indexes operand b.
    for (genvar g = 0; g < LANES; g++) begin : g_shuf
        logic [SEL_W-1:0] sel;
        assign sel = imm_i[g*SEL_W +: SEL_W];
        if (g < HALF) begin : g_src_a
            assign shf_l[g] = a_l[sel];
        end else begin : g_src_b
            assign shf_l[g] = b_l[sel];
        end
    end

    // Interleaves: even lanes from a, odd lanes from b.
    for (genvar k = 0; k < HALF; k++) begin : g_ilv
        assign ilo_l[2*k]   = a_l[k];
        assign ilo_l[2*k+1] = b_l[k];
        assign ihi_l[2*k]   = a_l[HALF+k];
        assign ihi_l[2*k+1] = b_l[HALF+k];
    end

    // Half moves.
    for (genvar g = 0; g < LANES; g++) begin : g_move
        if (g < HALF) begin : g_low
            assign h2l_l[g] = b_l[HALF+g];
            assign l2h_l[g] = a_l[g];
        end else begin : g_high
            assign h2l_l[g] = a_l[g];
            assign l2h_l[g] = b_l[g-HALF];
        end
    end

    always_comb begin
        hit_o = 1'b1;
        unique case (op_i)
            OPC_SHUF, OPC_ILVLO, OPC_ILVHI, OPC_HI2LO, OPC_LO2HI: hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mux
        always_comb begin
            res_o[g*LANE_W +: LANE_W] = '0;
            unique case (op_i)
                OPC_SHUF:  res_o[g*LANE_W +: LANE_W] = shf_l[g];
                OPC_ILVLO: res_o[g*LANE_W +: LANE_W] = ilo_l[g];
                OPC_ILVHI: res_o[g*LANE_W +: LANE_W] = ihi_l[g];
                OPC_HI2LO: res_o[g*LANE_W +: LANE_W] = h2l_l[g];
                OPC_LO2HI: res_o[g*LANE_W +: LANE_W] = l2h_l[g];
                default:   res_o[g*LANE_W +: LANE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int SEL_W = $clog2(LANES),
    localparam int IMM_W = LANES * SEL_W,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    output logic             out_valid,
    output logic [VEC_W-1:0] result,
    output logic             illegal
);
    import plu_pkg::*;

    logic [VEC_W-1:0] logic_res, route_res, next_res;
    logic             logic_hit, route_hit;
    emit_state_e      state_q, state_d;

    plu_bitwise #(.VEC_W(VEC_W)) u_bitwise (
        .op_i  (op),
        .a_i   (opa),
        .b_i   (opb),
        .res_o (logic_res),
        .hit_o (logic_hit)
    );

    plu_lane_route #(.LANE_W(LANE_W), .LANES(LANES)) u_route (
        .op_i  (op),
        .imm_i (imm),
        .a_i   (opa),
        .b_i   (opb),
        .res_o (route_res),
        .hit_o (route_hit)
    );

    always_comb begin
        if (logic_hit)      next_res = logic_res;
        else if (route_hit) next_res = route_res;
        else                next_res = opa;
    end

    // Sequencer: accept / drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= next_res;
            illegal <= !(logic_hit || route_hit);
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    // R2
    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));
    // R11
    p_unassigned_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd8) |=> (illegal && result == $past(opa)));
    // R11
    p_assigned_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op <= 4'd8) |=> !illegal);
    // R5
    p_andn_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd1) |=> ((result & $past(opa)) == '0));

endmodule

// File: tb/tb_lane_permute_unit.sv
`timescale 1ns/1ps
module tb_lane_permute_unit;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [3:0]   op;
    logic [7:0]   imm;
    logic [127:0] opa, opb;
    logic         out_valid;
    logic [127:0] result;
    logic         illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [127:0] exp_res;
    logic         exp_ill;
    logic         exp_val;

    always #2 clk = ~clk;

    lane_permute_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .imm(imm),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
        .illegal(illegal)
    );

    function automatic logic [31:0] lane(input logic [127:0] v, input int i);
        return v[32*i +: 32];
    endfunction

    function automatic logic [127:0] model(input int code, input logic [7:0] im,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        r = a;
        case (code)
            0: r = a & b;
            1: r = ~a & b;
            2: r = a | b;
            3: r = a ^ b;
            4: for (int i = 0; i < 4; i++) begin
                   int s;
                   s = int'(im[2*i +: 2]);
                   r[32*i +: 32] = (i < 2) ? lane(a, s) : lane(b, s);
               end
            5: r = {lane(b,1), lane(a,1), lane(b,0), lane(a,0)};
            6: r = {lane(b,3), lane(a,3), lane(b,2), lane(a,2)};
            7: r = {lane(a,3), lane(a,2), lane(b,3), lane(b,2)};
            8: r = {lane(b,1), lane(b,0), lane(a,1), lane(a,0)};
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0, 2, 3: return "R4";
            1: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R8";
            7: return "R9";
            8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check128(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
        end
    endtask

    // Drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input string tag, input bit v, input int code,
                        input logic [7:0] im, input logic [127:0] a, input logic [127:0] b);
        string t;
        in_valid = v; op = 4'(code); imm = im; opa = a; opb = b;
        @(posedge clk);
        if (v) begin
            exp_res = model(code, im, a, b);
            exp_ill = (code > 8);
        end
        exp_val = v;
        @(negedge clk);
        t = (tag != "") ? tag : (v ? tag_of(code) : "R3");
        check1("R2", "out_valid", out_valid, exp_val);
        check128(t, result, exp_res);
        check1(v ? "R11" : "R3", "illegal", illegal, exp_ill);
    endtask

    function automatic logic [127:0] pat(input logic [31:0] base);
        return {base + 32'h3, base + 32'h2, base + 32'h1, base};
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [127:0] a0, b0;
        rst_n = 1'b0; in_valid = 1'b0; op = '0; imm = '0; opa = '0; opb = '0;
        exp_res = '0; exp_ill = 1'b0; exp_val = 1'b0;
        repeat (3) @(negedge clk);
        check1("R1", "out_valid", out_valid, 1'b0);
        check128("R1", result, '0);
        check1("R1", "illegal", illegal, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", "out_valid", out_valid, 1'b0);
        check128("R1", result, '0);

        a0 = pat(32'hA000_0010);
        b0 = pat(32'hB000_0020);

        // R4, R5 fixed patterns
        step("R4", 1, 0, 8'h00, 128'hFF00_FF00_0F0F_F0F0_1234_5678_9ABC_DEF0, 128'h0FF0_0FF0_FFFF_0000_FFFF_0000_00FF_FF00);
        step("R5", 1, 1, 8'h00, 128'hFF00_FF00_0F0F_F0F0_1234_5678_9ABC_DEF0, 128'h0FF0_0FF0_FFFF_0000_FFFF_0000_00FF_FF00);
        step("R4", 1, 2, 8'h00, a0, b0);
        step("R4", 1, 3, 8'h00, a0, b0);
        // R6 several immediates
        step("R6", 1, 4, 8'hE4, a0, b0);
        step("R6", 1, 4, 8'h1B, a0, b0);
        step("R6", 1, 4, 8'h00, a0, b0);
        step("R6", 1, 4, 8'hFF, a0, b0);
        step("R6", 1, 4, 8'h4E, a0, b0);
        // R7..R10
        step("R7", 1, 5, 8'h00, a0, b0);
        step("R8", 1, 6, 8'h00, a0, b0);
        step("R9", 1, 7, 8'h00, a0, b0);
        step("R10", 1, 8, 8'h00, a0, b0);
        // R3 idle hold with changing inputs
        step("R3", 0, 2, 8'h55, b0, a0);
        step("R3", 0, 9, 8'hAA, ~a0, b0);
        // R11 unassigned codes, back-to-back with assigned
        step("R11", 1, 9, 8'h00, a0, b0);
        step("R6", 1, 4, 8'h1B, a0, b0);
        step("R11", 1, 15, 8'h33, b0, a0);
        step("R3", 0, 0, 8'h00, a0, a0);
        step("R7", 1, 5, 8'h00, b0, a0);
        // R12 immediate ignored on non-shuffle codes
        for (int c = 0; c < 9; c++) begin
            if (c != 4) begin
                step("R12", 1, c, 8'hC9, a0, b0);
                step("R12", 1, c, 8'h36, a0, b0);
            end
        end
        // Random mix, every code
        for (int n = 0; n < 300; n++) begin
            logic [127:0] ra, rb;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = {$urandom, $urandom, $urandom, $urandom};
            step("", ($urandom % 4) != 0, int'($urandom % 16), 8'($urandom), ra, rb);
        end
        // R1 reset mid-stream
        in_valid = 1'b1; op = 4'd3;
        rst_n = 1'b0;
        @(posedge clk);
        exp_res = '0; exp_ill = 1'b0; exp_val = 1'b0;
        @(negedge clk);
        check1("R1", "out_valid", out_valid, 1'b0);
        check128("R1", result, '0);
        check1("R1", "illegal", illegal, 1'b0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        step("R11", 1, 12, 8'h00, a0, b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule